// File: doc/BRIEF.md
# Edit Distance Tile Engine

This block evaluates one 8x8 tile of the dynamic-programming matrix used to compute the edit (Levenshtein) distance between two character strings. A tile pairs eight characters of string A, one per matrix row, with eight characters of string B, one per matrix column. Three boundary inputs are needed: the column of cells just left of the tile, the row of cells just above it, and the single cell diagonally above-left of it. From these the engine produces the tile's rightmost column, its bottom row and its bottom-right cell. Those outputs are exactly the boundary inputs that the tiles to the right, below and diagonally below-right need, so tiles chain across a matrix of any size.

A one-cycle start request, accepted only while the engine is idle, captures all inputs. The engine then walks the 64 cells in row-major order, one cell per cycle, on a fixed schedule. The whole job takes 83 cycles: one load cycle, ten cycles per row (one setup, eight cells, one write-back) and one flush cycle before a one-cycle done pulse. The results stay on the outputs until the next start is accepted.

Top module: `ed_tile_engine`

## Requirements
- R1: Each tile cell c(i,j) with i,j in 1..8 equals the minimum of c(i-1,j-1)+cost, c(i,j-1)+1 and c(i-1,j)+1, using unsigned 32-bit cell values.
- R2: The cost is 0 when the 8-bit character of tile row i, taken from a_chars_i bits [8(i-1)+7:8(i-1)], equals the 8-bit character of tile column j, taken from b_chars_i bits [8(j-1)+7:8(j-1)]. Otherwise the cost is 1.
- R3: Boundary layout, with 32-bit slice k at bits [32k+31:32k] for k in 0..7. Inputs: left_i slice k is c(k+1,0), top_i slice k is c(0,k+1), corner_i is c(0,0). Outputs: right_o slice k is c(k+1,8), bottom_o slice k is c(8,k+1), corner_o is c(8,8).
- R4: Supplying global edges c(i,0)=i and c(0,j)=j, and feeding each tile's outputs into its right and lower neighbours, yields the full edit distance at the last tile's corner_o.
- R5: A start is accepted when start_i is high while busy_o is low. busy_o is then high for 83 cycles, and done_o is high in the 83rd of them, counting the cycle right after the accepting clock edge as the first.
- R6: done_o is high for exactly one cycle per accepted start, and busy_o is low in the following cycle.
- R7: A start request, or any change of the data inputs, while busy_o is high has no effect: the running tile keeps its latency and its results.
- R8: From the done cycle until the next accepted start, right_o, bottom_o and corner_o hold their values.
- R9: After reset, busy_o and done_o are low and all result outputs are zero.
- R10: When done_o is high, corner_o equals slice 7 of right_o and slice 7 of bottom_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted while idle |
| a_chars_i | input | 64 | Eight characters of string A, one per tile row |
| b_chars_i | input | 64 | Eight characters of string B, one per tile column |
| left_i | input | 256 | Left boundary column c(1..8,0) |
| top_i | input | 256 | Top boundary row c(0,1..8) |
| corner_i | input | 32 | Top-left corner c(0,0) |
| busy_o | output | 1 | Tile in progress |
| done_o | output | 1 | One-cycle completion pulse |
| right_o | output | 256 | Right column c(1..8,8) |
| bottom_o | output | 256 | Bottom row c(8,1..8) |
| corner_o | output | 32 | Bottom-right cell c(8,8) |

## Verification
Four properties are checked on every cycle. The first is the schedule: done arrives exactly 83 cycles after acceptance, lasts one cycle, and busy never drops early. The second is that results hold between done and the next accepted start. The third is that the corner agrees with the last slices of both output vectors. The fourth is that acceptance always leads into a busy state. The arithmetic itself can only be shown by the bench's scenarios, which compare outputs against an independent matrix model. These scenarios cover random small-alphabet strings, all-matching and all-differing strings, arbitrary non-edge boundaries, a four-tile chain compared against a whole-matrix distance, and start requests and input changes injected mid-tile.

// File: rtl/ed_tile_pkg.sv
`timescale 1ns/1ps
package ed_tile_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ROWSET,
    ST_CELL,
    ST_ROWEND,
    ST_FLUSH,
    ST_DONE
  } ed_state_e;
endpackage

// File: rtl/ed_tile_ctrl.sv
`timescale 1ns/1ps
module ed_tile_ctrl
  import ed_tile_pkg::*;
#(
  parameter int unsigned TILE  = 8,
  parameter int unsigned IDX_W = (TILE > 1) ? $clog2(TILE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output ed_state_e        state_o,
  output logic [IDX_W-1:0] row_o,
  output logic [IDX_W-1:0] col_o,
  output logic             accept_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TILE - 1);

  ed_state_e        state_q;
  logic [IDX_W-1:0] row_q, col_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (start_i) state_q <= ST_LOAD;
        ST_LOAD: begin
          state_q <= ST_ROWSET;
          row_q   <= '0;
        end
        ST_ROWSET: begin
          state_q <= ST_CELL;
          col_q   <= '0;
        end
        ST_CELL: begin
          if (col_q == LAST) state_q <= ST_ROWEND;
          else               col_q   <= col_q + 1'b1;
        end
        ST_ROWEND: begin
          if (row_q == LAST) state_q <= ST_FLUSH;
          else begin
            row_q   <= row_q + 1'b1;
            state_q <= ST_ROWSET;
          end
        end
        ST_FLUSH:  state_q <= ST_DONE;
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
endmodule

// File: rtl/ed_tile_cell.sv
`timescale 1ns/1ps
module ed_tile_cell #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CELL_W = 32
) (
  input  logic [CHAR_W-1:0] a_ch_i,
  input  logic [CHAR_W-1:0] b_ch_i,
  input  logic [CELL_W-1:0] diag_i,
  input  logic [CELL_W-1:0] left_i,
  input  logic [CELL_W-1:0] up_i,
  output logic [CELL_W-1:0] val_o
);
  logic [CELL_W-1:0] via_diag, via_left, via_up, best_lu;

  always_comb begin
    via_diag = diag_i + CELL_W'(a_ch_i != b_ch_i);
    via_left = left_i + CELL_W'(1);
    via_up   = up_i + CELL_W'(1);
    best_lu  = (via_left < via_up) ? via_left : via_up;
    val_o    = (via_diag < best_lu) ? via_diag : best_lu;
  end
endmodule

// File: rtl/ed_tile_dp.sv
`timescale 1ns/1ps
module ed_tile_dp
  import ed_tile_pkg::*;
#(
  parameter int unsigned TILE   = 8,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CELL_W = 32,
  parameter int unsigned IDX_W  = (TILE > 1) ? $clog2(TILE) : 1,
  parameter int unsigned STR_W  = TILE * CHAR_W,
  parameter int unsigned VEC_W  = TILE * CELL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  ed_state_e         state_i,
  input  logic [IDX_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  col_i,
  input  logic [STR_W-1:0]  a_chars_i,
  input  logic [STR_W-1:0]  b_chars_i,
  input  logic [VEC_W-1:0]  left_i,
  input  logic [VEC_W-1:0]  top_i,
  input  logic [CELL_W-1:0] corner_i,
  output logic [VEC_W-1:0]  right_o,
  output logic [VEC_W-1:0]  bottom_o,
  output logic [CELL_W-1:0] corner_o
);
  logic [CHAR_W-1:0] a_q [TILE];
  logic [CHAR_W-1:0] b_q [TILE];
  logic [CELL_W-1:0] left_q [TILE];
  logic [CELL_W-1:0] row_buf [TILE];  // c(i-1, 1..TILE), becomes bottom row
  logic [CELL_W-1:0] right_q [TILE];
  logic [CELL_W-1:0] corner_in_q, diag_q, run_q, cell_val;

  ed_tile_cell #(.CHAR_W(CHAR_W), .CELL_W(CELL_W)) u_cell (
    .a_ch_i (a_q[row_i]),
    .b_ch_i (b_q[col_i]),
    .diag_i (diag_q),
    .left_i (run_q),
    .up_i   (row_buf[col_i]),
    .val_o  (cell_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TILE; k++) begin
        a_q[k]     <= '0;
        b_q[k]     <= '0;
        left_q[k]  <= '0;
        row_buf[k] <= '0;
        right_q[k] <= '0;
      end
      corner_in_q <= '0;
      diag_q      <= '0;
      run_q       <= '0;
    end else if (accept_i) begin
      for (int k = 0; k < TILE; k++) begin
        a_q[k]     <= a_chars_i[k*CHAR_W +: CHAR_W];
        b_q[k]     <= b_chars_i[k*CHAR_W +: CHAR_W];
        left_q[k]  <= left_i[k*CELL_W +: CELL_W];
        row_buf[k] <= top_i[k*CELL_W +: CELL_W];
      end
      corner_in_q <= corner_i;
    end else begin
      unique case (state_i)
        ST_ROWSET: begin
          diag_q <= (row_i == '0) ? corner_in_q : left_q[row_i - 1'b1];
          run_q  <= left_q[row_i];
        end
        ST_CELL: begin
          row_buf[col_i] <= cell_val;
          diag_q         <= row_buf[col_i];
          run_q          <= cell_val;
        end
        ST_ROWEND: right_q[row_i] <= run_q;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < TILE; g++) begin : g_out
    assign right_o[g*CELL_W +: CELL_W]  = right_q[g];
    assign bottom_o[g*CELL_W +: CELL_W] = row_buf[g];
  end
  assign corner_o = right_q[TILE-1];
endmodule

// File: rtl/ed_tile_engine.sv
`timescale 1ns/1ps
module ed_tile_engine
  import ed_tile_pkg::*;
#(
  parameter int unsigned TILE   = 8,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CELL_W = 32,
  localparam int unsigned IDX_W = (TILE > 1) ? $clog2(TILE) : 1,
  localparam int unsigned STR_W = TILE * CHAR_W,
  localparam int unsigned VEC_W = TILE * CELL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STR_W-1:0]  a_chars_i,
  input  logic [STR_W-1:0]  b_chars_i,
  input  logic [VEC_W-1:0]  left_i,
  input  logic [VEC_W-1:0]  top_i,
  input  logic [CELL_W-1:0] corner_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [VEC_W-1:0]  right_o,
  output logic [VEC_W-1:0]  bottom_o,
  output logic [CELL_W-1:0] corner_o
);
  ed_state_e        state;
  logic [IDX_W-1:0] row, col;
  logic             accept;

  ed_tile_ctrl #(.TILE(TILE), .IDX_W(IDX_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .state_o  (state),
    .row_o    (row),
    .col_o    (col),
    .accept_o (accept)
  );

  ed_tile_dp #(
    .TILE(TILE), .CHAR_W(CHAR_W), .CELL_W(CELL_W),
    .IDX_W(IDX_W), .STR_W(STR_W), .VEC_W(VEC_W)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .state_i   (state),
    .row_i     (row),
    .col_i     (col),
    .a_chars_i (a_chars_i),
    .b_chars_i (b_chars_i),
    .left_i    (left_i),
    .top_i     (top_i),
    .corner_i  (corner_i),
    .right_o   (right_o),
    .bottom_o  (bottom_o),
    .corner_o  (corner_o)
  );

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);
endmodule

// File: rtl/ed_tile_engine_chk.sv
`timescale 1ns/1ps
module ed_tile_engine_chk #(
  parameter int unsigned TILE   = 8,
  parameter int unsigned CELL_W = 32,
  localparam int unsigned VEC_W = TILE * CELL_W,
  localparam int unsigned LAT   = 3 + TILE * (TILE + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [VEC_W-1:0]  right_o,
  input logic [VEC_W-1:0]  bottom_o,
  input logic [CELL_W-1:0] corner_o
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (!busy_o) busy_cnt <= '0;
    else             busy_cnt <= busy_cnt + 16'd1;
  end

  p_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt == 16'(LAT - 1)));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || (!busy_o && !start_i)) |=>
      ($stable(right_o) && $stable(bottom_o) && $stable(corner_o)));

  p_corner_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (corner_o == bottom_o[VEC_W-1 -: CELL_W]));
endmodule

bind ed_tile_engine ed_tile_engine_chk #(.TILE(TILE), .CELL_W(CELL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .right_o  (right_o),
  .bottom_o (bottom_o),
  .corner_o (corner_o)
);

// File: tb/ed_tile_engine_test.sv
`timescale 1ns/1ps
module ed_tile_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int T   = 8;
  localparam int LAT = 83;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  a_chars_i = '0, b_chars_i = '0;
  logic [255:0] left_i = '0, top_i = '0;
  logic [31:0]  corner_i = '0;
  logic         busy_o, done_o;
  logic [255:0] right_o, bottom_o;
  logic [31:0]  corner_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ed_tile_engine uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_chars_i(a_chars_i), .b_chars_i(b_chars_i),
    .left_i(left_i), .top_i(top_i), .corner_i(corner_i),
    .busy_o(busy_o), .done_o(done_o),
    .right_o(right_o), .bottom_o(bottom_o), .corner_o(corner_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // independent model of one tile
  task automatic ref_tile(input logic [63:0] a, input logic [63:0] b,
                          input logic [255:0] l, input logic [255:0] t,
                          input logic [31:0] c,
                          output logic [255:0] er, output logic [255:0] eb,
                          output logic [31:0] ec);
    longint m [0:8][0:8];
    longint best;
    m[0][0] = c;
    for (int i = 1; i <= T; i++) m[i][0] = l[(i-1)*32 +: 32];
    for (int j = 1; j <= T; j++) m[0][j] = t[(j-1)*32 +: 32];
    for (int i = 1; i <= T; i++)
      for (int j = 1; j <= T; j++) begin
        best = m[i-1][j-1] + ((a[(i-1)*8 +: 8] == b[(j-1)*8 +: 8]) ? 0 : 1);
        if (m[i][j-1] + 1 < best) best = m[i][j-1] + 1;
        if (m[i-1][j] + 1 < best) best = m[i-1][j] + 1;
        m[i][j] = best;
      end
    for (int k = 0; k < T; k++) begin
      er[k*32 +: 32] = 32'(m[k+1][T]);
      eb[k*32 +: 32] = 32'(m[T][k+1]);
    end
    ec = 32'(m[T][T]);
  endtask

  function automatic int full_dist(input logic [127:0] a, input logic [127:0] b);
    int m [0:16][0:16];
    int best;
    for (int i = 0; i <= 16; i++) m[i][0] = i;
    for (int j = 0; j <= 16; j++) m[0][j] = j;
    for (int i = 1; i <= 16; i++)
      for (int j = 1; j <= 16; j++) begin
        best = m[i-1][j-1] + ((a[(i-1)*8 +: 8] == b[(j-1)*8 +: 8]) ? 0 : 1);
        if (m[i][j-1] + 1 < best) best = m[i][j-1] + 1;
        if (m[i-1][j] + 1 < best) best = m[i-1][j] + 1;
        m[i][j] = best;
      end
    return m[16][16];
  endfunction

  // runs one tile; inject>0 raises start and scrambles inputs in that busy cycle
  task automatic run_tile(input logic [63:0] a, input logic [63:0] b,
                          input logic [255:0] l, input logic [255:0] t,
                          input logic [31:0] c, input int inject,
                          output logic [255:0] r, output logic [255:0] bo,
                          output logic [31:0] co, output int lat);
    @(negedge clk_i);
    a_chars_i = a; b_chars_i = b; left_i = l; top_i = t; corner_i = c;
    start_i = 1'b1;
    @(posedge clk_i);
    lat = 0;
    for (int n = 1; n <= 200; n++) begin
      @(negedge clk_i);
      start_i = (n == inject);
      if (n == inject) begin
        a_chars_i = ~a; b_chars_i = {b[31:0], b[63:32]};
        left_i = ~l; top_i = ~t; corner_i = c + 32'd5;
      end
      if (done_o) begin
        lat = n;
        break;
      end
    end
    start_i = 1'b0;
    r = right_o; bo = bottom_o; co = corner_o;
  endtask

  task automatic compare_tile(input string tag, input logic [63:0] a,
                              input logic [63:0] b, input logic [255:0] l,
                              input logic [255:0] t, input logic [31:0] c,
                              input logic [255:0] r, input logic [255:0] bo,
                              input logic [31:0] co);
    logic [255:0] er, eb;
    logic [31:0]  ec;
    ref_tile(a, b, l, t, c, er, eb, ec);
    for (int k = 0; k < T; k++) begin
      chk(r[k*32 +: 32] == er[k*32 +: 32], tag, "R1 R3 right slice",
          r[k*32 +: 32], er[k*32 +: 32]);
      chk(bo[k*32 +: 32] == eb[k*32 +: 32], tag, "R1 R3 bottom slice",
          bo[k*32 +: 32], eb[k*32 +: 32]);
    end
    chk(co == ec, tag, "R3 corner", co, ec);
    chk(co == r[255:224] && co == bo[255:224], "R10", "corner vs last slices",
        co, r[255:224]);
  endtask

  function automatic logic [255:0] edge_vec(input int base);
    logic [255:0] v;
    for (int k = 0; k < T; k++) v[k*32 +: 32] = 32'(base + k + 1);
    return v;
  endfunction

  function automatic logic [63:0] rand_str();
    logic [63:0] s;
    for (int k = 0; k < T; k++) s[k*8 +: 8] = 8'(8'h61 + ($urandom % 4));
    return s;
  endfunction

  task automatic t_reset();
    chk(!busy_o && !done_o, "R9", "busy/done after reset", {busy_o, done_o}, 0);
    chk(right_o == '0 && bottom_o == '0, "R9", "vectors after reset",
        right_o[31:0], 0);
    chk(corner_o == '0, "R9", "corner after reset", corner_o, 0);
  endtask

  task automatic t_random_global();
    logic [63:0] a, b;
    logic [255:0] r, bo;
    logic [31:0] co;
    int lat;
    for (int it = 0; it < 4; it++) begin
      a = rand_str(); b = rand_str();
      run_tile(a, b, edge_vec(0), edge_vec(0), 32'd0, 0, r, bo, co, lat);
      chk(lat == LAT, "R5", "latency", lat, LAT);
      compare_tile("R2", a, b, edge_vec(0), edge_vec(0), 32'd0, r, bo, co);
    end
  endtask

  task automatic t_equal_and_diff();
    logic [255:0] r, bo;
    logic [31:0] co;
    int lat;
    run_tile({8{8'h78}}, {8{8'h78}}, edge_vec(0), edge_vec(0), 32'd0, 0,
             r, bo, co, lat);
    chk(co == 0, "R2", "all-equal distance", co, 0);
    compare_tile("R2", {8{8'h78}}, {8{8'h78}}, edge_vec(0), edge_vec(0), 32'd0,
                 r, bo, co);
    run_tile({8{8'h78}}, {8{8'h79}}, edge_vec(0), edge_vec(0), 32'd0, 0,
             r, bo, co, lat);
    chk(co == 8, "R2", "all-differ distance", co, 8);
  endtask

  task automatic t_inner_bounds();
    logic [63:0] a, b;
    logic [255:0] l, t, r, bo;
    logic [31:0] c, co;
    int lat;
    a = rand_str(); b = rand_str();
    c = 32'd1000 + ($urandom % 4);
    for (int k = 0; k < T; k++) begin
      l[k*32 +: 32] = c + 32'(k) + 32'($urandom % 2);
      t[k*32 +: 32] = c + 32'(k) + 32'($urandom % 3);
    end
    run_tile(a, b, l, t, c, 0, r, bo, co, lat);
    compare_tile("R3", a, b, l, t, c, r, bo, co);
  endtask

  task automatic t_done_pulse();
    logic [255:0] r, bo;
    logic [31:0] co;
    int lat;
    run_tile(rand_str(), rand_str(), edge_vec(0), edge_vec(0), 32'd0, 0,
             r, bo, co, lat);
    @(negedge clk_i);
    chk(!done_o, "R6", "done after one cycle", done_o, 0);
    chk(!busy_o, "R6", "idle after done", busy_o, 0);
  endtask

  task automatic t_busy_start();
    logic [63:0] a, b;
    logic [255:0] r, bo;
    logic [31:0] co;
    int lat;
    a = rand_str(); b = rand_str();
    run_tile(a, b, edge_vec(0), edge_vec(0), 32'd0, 40, r, bo, co, lat);
    chk(lat == LAT, "R7", "latency with start mid-tile", lat, LAT);
    compare_tile("R7", a, b, edge_vec(0), edge_vec(0), 32'd0, r, bo, co);
    @(negedge clk_i);
    chk(!busy_o, "R7", "no restart from ignored start", busy_o, 0);
  endtask

  task automatic t_hold();
    logic [255:0] r, bo;
    logic [31:0] co;
    int lat;
    run_tile(rand_str(), rand_str(), edge_vec(0), edge_vec(0), 32'd0, 0,
             r, bo, co, lat);
    a_chars_i = '1; left_i = '1; top_i = '0; corner_i = 32'd77;
    repeat (12) @(negedge clk_i);
    chk(right_o == r && bottom_o == bo, "R8", "vectors held",
        right_o[31:0], r[31:0]);
    chk(corner_o == co, "R8", "corner held", corner_o, co);
  endtask

  task automatic t_chain();
    logic [127:0] sa, sb;
    logic [255:0] r00, b00, r01, b01, r10, b10, r11, b11;
    logic [31:0]  c00, c01, c10, c11;
    int lat, exp_d;
    for (int k = 0; k < 16; k++) begin
      sa[k*8 +: 8] = 8'(8'h61 + ($urandom % 3));
      sb[k*8 +: 8] = 8'(8'h61 + ($urandom % 3));
    end
    run_tile(sa[63:0], sb[63:0], edge_vec(0), edge_vec(0), 32'd0, 0,
             r00, b00, c00, lat);
    run_tile(sa[63:0], sb[127:64], r00, edge_vec(8), 32'd8, 0,
             r01, b01, c01, lat);
    run_tile(sa[127:64], sb[63:0], edge_vec(8), b00, 32'd8, 0,
             r10, b10, c10, lat);
    run_tile(sa[127:64], sb[127:64], r10, b01, c00, 0, r11, b11, c11, lat);
    exp_d = full_dist(sa, sb);
    chk(c11 == 32'(exp_d), "R4", "chained 16x16 distance", c11, exp_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_random_global();
    t_equal_and_diff();
    t_inner_bounds();
    t_done_pulse();
    t_busy_start();
    t_hold();
    t_chain();
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule